// File: doc/BRIEF.md
# Quasi-bidirectional port with interrupt capture

This block is one eight-bit I/O port of the weak-pull-up, strong-pull-down kind used on small microcontrollers. Each bit owns a write latch; the pad is pulled low when either that latch bit or the bit's alternate-function output is 0, and it floats high through a weak pull-up only when both are 1. The pad is modelled as a resolved level from the board plus a pull-down enable driven by the block. The level seen on the pin is synchronized and then serves three consumers: the CPU pin read, the alternate-function input, and two interrupt-capture channels.

The CPU changes the latch in two ways. A byte write replaces all eight bits. A read-modify-write reads the latch byte, changes one addressed bit, and writes all eight back. A fault-injection input can knock unaddressed bits to 0 during that write-back. Two fixed bits (2 and 3) also act as external interrupt inputs. Their alternate-function outputs are tied high. Each channel raises a request flag on a falling edge or on a low level, whether or not the interrupt is enabled. Because these channels share the latch, a 0 left in an interrupt bit's latch holds the pin low and hides every later edge until software writes a 1 back.

The CPU access and interrupt pins are plain single-cycle control strobes with no back-pressure: every strobe is taken in the cycle it is high, so there is no valid/ready pair at the edge.

Top module: `qbp_port`

## Requirements
- R1: After reset every latch bit is 1, `pad_pd` is all 0, both request flags are 0, `tst_bit` is 0, and `pin_rd` reads all 1 while the board releases every pad.
- R2: `pad_pd[i]` is 1 exactly when latch bit i is 0 or `alt_out[i]` is 0; it changes in the cycle after the latch write, with no extra delay after `alt_out` changes.
- R3: `pin_rd[i]` equals `pad_ext[i] & ~pad_pd[i]` as sampled two clock edges earlier (two-flop synchronizer, reset value 1).
- R4: `alt_in` carries the same synchronized pin level as `pin_rd`.
- R5: `alt_out` has no effect on bits 2 and 3: with their latch bits at 1, `pad_pd[2]` and `pad_pd[3]` stay 0 for any `alt_out`.
- R6: With `rmw_en` high, `rmw_op` selects the change to latch bit `rmw_bit`: 0 sets it, 1 clears it, 2 tests and clears it, 3 leaves it unchanged. The other seven bits are written back from the latch, not from the pins.
- R7: During a read-modify-write, each unaddressed bit whose `disturb` bit is 1 is written back as 0. The addressed bit is never disturbed. `disturb` has no effect on byte writes or in idle cycles.
- R8: After any read-modify-write, `tst_bit` holds the value the addressed latch bit had before that operation, from the following cycle onward.
- R9: Channel c (c=0 for pin 2, c=1 for pin 3) with `irq_mode[c]`=1 sets `irq_flag[c]` one cycle after the synchronized pin goes from 1 to 0. With `irq_mode[c]`=0 it sets the flag in the cycle after every cycle in which the synchronized pin is 0.
- R10: The flag is set regardless of `irq_en[c]`; `irq_req[c]` is `irq_flag[c] & irq_en[c]`.
- R11: A flag is cleared by `irq_ack[c]` or by `flag_wr_en` with `flag_wr_data[c]`=0 (with 1 it is set). A capture event in the same cycle wins over either clear.
- R12: While the latch bit of an interrupt pin is 0, toggling `pad_ext` on that pin sets no flag. A capture works again once a 1 is written back.
- R13: When `wr_en` and `rmw_en` are high in the same cycle, the byte write takes effect and the read-modify-write is dropped.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| pad_ext | input | 8 | Board-side pad level, 1 = released, 0 = pulled low externally |
| pad_pd | output | 8 | Pull-down enable per pad |
| alt_out | input | 8 | Alternate-function outputs (ignored on bits 2 and 3) |
| alt_in | output | 8 | Synchronized pin levels for alternate functions |
| wr_en | input | 1 | Byte write strobe |
| wr_data | input | 8 | Byte write value |
| rmw_en | input | 1 | Read-modify-write strobe |
| rmw_op | input | 2 | 0 set, 1 clear, 2 test-and-clear, 3 keep |
| rmw_bit | input | 3 | Addressed bit of a read-modify-write |
| disturb | input | 8 | Fault-injection mask applied to unaddressed bits on write-back |
| tst_bit | output | 1 | Prior value of the last read-modify-write's addressed bit |
| pin_rd | output | 8 | Pin read data (synchronized levels) |
| irq_mode | input | 2 | Per channel: 1 edge capture, 0 level capture |
| irq_en | input | 2 | Per channel interrupt enable |
| irq_ack | input | 2 | Per channel acknowledge, clears the flag |
| flag_wr_en | input | 1 | Software write of both flags |
| flag_wr_data | input | 2 | Flag values written by software |
| irq_flag | output | 2 | Captured request flags |
| irq_req | output | 2 | Enabled requests to the CPU |

## Verification
The two functions that can collide are a flag clear (an acknowledge or a software write of 0) and a new capture on the same channel. The bench provokes this by dropping the pin and holding `irq_ack` on exactly the edge where the synchronized falling edge is scored, three edges after the pad change. The flag must still read 1 afterwards, and a lone acknowledge one cycle later must clear it. The same-cycle byte write against read-modify-write contest is provoked by pulsing both strobes together and reading the outcome from `pad_pd`.

// File: rtl/qbp_pkg.sv
package qbp_pkg;
  typedef enum logic [1:0] {
    RMW_SET    = 2'd0,
    RMW_CLR    = 2'd1,
    RMW_TSTCLR = 2'd2,
    RMW_KEEP   = 2'd3
  } rmw_op_e;
endpackage

// File: rtl/qbp_sync.sv
module qbp_sync #(
  parameter int W      = 8,
  parameter int STAGES = 2
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  logic [W-1:0] stg [STAGES];

  generate
    for (genvar s = 0; s < STAGES; s++) begin : g_stage
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) stg[s] <= '1;
        else if (s == 0) stg[s] <= d;
        else stg[s] <= stg[(s == 0) ? 0 : s-1];
      end
    end
  endgenerate

  assign q = stg[STAGES-1];
endmodule

// File: rtl/qbp_latch.sv
module qbp_latch
  import qbp_pkg::*;
#(
  parameter int W  = 8,
  localparam int BW = $clog2(W)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          wr_en,
  input  logic [W-1:0]  wr_data,
  input  logic          rmw_en,
  input  rmw_op_e       rmw_op,
  input  logic [BW-1:0] rmw_bit,
  input  logic [W-1:0]  disturb,
  output logic [W-1:0]  lat_q,
  output logic          tst_q
);
  logic [W-1:0] sel_mask;
  logic [W-1:0] mod_val;
  logic [W-1:0] lat_d;

  assign sel_mask = {{(W-1){1'b0}}, 1'b1} << rmw_bit;

  always_comb begin
    unique case (rmw_op)
      RMW_SET:    mod_val = lat_q | sel_mask;
      RMW_CLR,
      RMW_TSTCLR: mod_val = lat_q & ~sel_mask;
      default:    mod_val = lat_q;
    endcase
  end

  always_comb begin
    if (wr_en)       lat_d = wr_data;
    else if (rmw_en) lat_d = mod_val & ~(disturb & ~sel_mask);
    else             lat_d = lat_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      lat_q <= '1;
      tst_q <= 1'b0;
    end else begin
      lat_q <= lat_d;
      if (rmw_en && !wr_en) tst_q <= lat_q[rmw_bit];
    end
  end
endmodule

// File: rtl/qbp_irq_chan.sv
module qbp_irq_chan (
  input  logic clk,
  input  logic rst_n,
  input  logic pin_s,
  input  logic edge_mode,
  input  logic ack,
  input  logic sw_wr,
  input  logic sw_val,
  output logic flag
);
  logic prev_q;
  logic capture;

  assign capture = edge_mode ? (prev_q & ~pin_s) : ~pin_s;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      prev_q <= 1'b1;
      flag   <= 1'b0;
    end else begin
      prev_q <= pin_s;
      if (capture)    flag <= 1'b1;
      else if (ack)   flag <= 1'b0;
      else if (sw_wr) flag <= sw_val;
    end
  end
endmodule

// File: rtl/qbp_port.sv
module qbp_port
  import qbp_pkg::*;
#(
  parameter int W           = 8,
  parameter int INT0_BIT    = 2,
  parameter int INT1_BIT    = 3,
  parameter int SYNC_STAGES = 2,
  localparam int BW    = $clog2(W),
  localparam int N_IRQ = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [W-1:0]     pad_ext,
  output logic [W-1:0]     pad_pd,
  input  logic [W-1:0]     alt_out,
  output logic [W-1:0]     alt_in,
  input  logic             wr_en,
  input  logic [W-1:0]     wr_data,
  input  logic             rmw_en,
  input  logic [1:0]       rmw_op,
  input  logic [BW-1:0]    rmw_bit,
  input  logic [W-1:0]     disturb,
  output logic             tst_bit,
  output logic [W-1:0]     pin_rd,
  input  logic [N_IRQ-1:0] irq_mode,
  input  logic [N_IRQ-1:0] irq_en,
  input  logic [N_IRQ-1:0] irq_ack,
  input  logic             flag_wr_en,
  input  logic [N_IRQ-1:0] flag_wr_data,
  output logic [N_IRQ-1:0] irq_flag,
  output logic [N_IRQ-1:0] irq_req
);
  logic [W-1:0] lat_q;
  logic [W-1:0] alt_eff;
  logic [W-1:0] pin_raw;
  logic [W-1:0] pin_s;

  qbp_latch #(.W(W)) u_latch (
    .clk     (clk),
    .rst_n   (rst_n),
    .wr_en   (wr_en),
    .wr_data (wr_data),
    .rmw_en  (rmw_en),
    .rmw_op  (rmw_op_e'(rmw_op)),
    .rmw_bit (rmw_bit),
    .disturb (disturb),
    .lat_q   (lat_q),
    .tst_q   (tst_bit)
  );

  generate
    for (genvar i = 0; i < W; i++) begin : g_alt
      if (i == INT0_BIT || i == INT1_BIT) begin : g_tied
        assign alt_eff[i] = 1'b1;
      end else begin : g_free
        assign alt_eff[i] = alt_out[i];
      end
    end
  endgenerate

  assign pad_pd  = ~(lat_q & alt_eff);
  assign pin_raw = pad_ext & ~pad_pd;

  qbp_sync #(.W(W), .STAGES(SYNC_STAGES)) u_sync (
    .clk   (clk),
    .rst_n (rst_n),
    .d     (pin_raw),
    .q     (pin_s)
  );

  assign pin_rd = pin_s;
  assign alt_in = pin_s;

  generate
    for (genvar c = 0; c < N_IRQ; c++) begin : g_irq
      localparam int PB = (c == 0) ? INT0_BIT : INT1_BIT;
      qbp_irq_chan u_chan (
        .clk       (clk),
        .rst_n     (rst_n),
        .pin_s     (pin_s[PB]),
        .edge_mode (irq_mode[c]),
        .ack       (irq_ack[c]),
        .sw_wr     (flag_wr_en),
        .sw_val    (flag_wr_data[c]),
        .flag      (irq_flag[c])
      );
    end
  endgenerate

  assign irq_req = irq_flag & irq_en;
endmodule

// File: rtl/qbp_port_chk.sv
module qbp_port_chk #(
  parameter int W        = 8,
  parameter int INT0_BIT = 2,
  parameter int INT1_BIT = 3,
  localparam int BW = $clog2(W)
) (
  input logic          clk,
  input logic          rst_n,
  input logic          wr_en,
  input logic [W-1:0]  wr_data,
  input logic          rmw_en,
  input logic [BW-1:0] rmw_bit,
  input logic [W-1:0]  disturb,
  input logic [W-1:0]  lat_q,
  input logic [W-1:0]  pad_pd,
  input logic [W-1:0]  pin_s,
  input logic [1:0]    irq_mode,
  input logic [1:0]    irq_ack,
  input logic          flag_wr_en,
  input logic [1:0]    flag_wr_data,
  input logic [1:0]    irq_flag
);
  localparam logic [W-1:0] ONE = {{(W-1){1'b0}}, 1'b1};

  AST_INT_PIN_FOLLOWS_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en |=> (pad_pd[INT0_BIT] == !$past(wr_data[INT0_BIT]))
           && (pad_pd[INT1_BIT] == !$past(wr_data[INT1_BIT]))); // R5

  AST_RMW_KEEPS_OTHERS: assert property (@(posedge clk) disable iff (!rst_n)
    (rmw_en && !wr_en && disturb == '0)
      |=> (((lat_q ^ $past(lat_q)) & ~(ONE << $past(rmw_bit))) == '0)); // R6

  AST_IDLE_LATCH_STABLE: assert property (@(posedge clk) disable iff (!rst_n)
    (!rmw_en && !wr_en) |=> $stable(lat_q)); // R7

  generate
    for (genvar c = 0; c < 2; c++) begin : g_ch
      localparam int PB = (c == 0) ? INT0_BIT : INT1_BIT;

      AST_EDGE_CAPTURE: assert property (@(posedge clk) disable iff (!rst_n)
        ($fell(pin_s[PB]) && irq_mode[c]) |=> irq_flag[c]); // R9

      AST_LEVEL_CAPTURE: assert property (@(posedge clk) disable iff (!rst_n)
        (!pin_s[PB] && !irq_mode[c]) |=> irq_flag[c]); // R9

      AST_FLAG_CLEAR_CAUSE: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(irq_flag[c])
          |-> $past(irq_ack[c] || (flag_wr_en && !flag_wr_data[c]))); // R11
    end
  endgenerate
endmodule

bind qbp_port qbp_port_chk #(
  .W(W), .INT0_BIT(INT0_BIT), .INT1_BIT(INT1_BIT)
) u_chk (
  .clk          (clk),
  .rst_n        (rst_n),
  .wr_en        (wr_en),
  .wr_data      (wr_data),
  .rmw_en       (rmw_en),
  .rmw_bit      (rmw_bit),
  .disturb      (disturb),
  .lat_q        (lat_q),
  .pad_pd       (pad_pd),
  .pin_s        (pin_s),
  .irq_mode     (irq_mode),
  .irq_ack      (irq_ack),
  .flag_wr_en   (flag_wr_en),
  .flag_wr_data (flag_wr_data),
  .irq_flag     (irq_flag)
);

// File: tb/sim_qbp_port.sv
module sim_qbp_port;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [7:0] pad_ext = 8'hFF;
  logic [7:0] pad_pd;
  logic [7:0] alt_out = 8'hFF;
  logic [7:0] alt_in;
  logic       wr_en = 1'b0;
  logic [7:0] wr_data = 8'h00;
  logic       rmw_en = 1'b0;
  logic [1:0] rmw_op = 2'd0;
  logic [2:0] rmw_bit = 3'd0;
  logic [7:0] disturb = 8'h00;
  logic       tst_bit;
  logic [7:0] pin_rd;
  logic [1:0] irq_mode = 2'b11;
  logic [1:0] irq_en = 2'b00;
  logic [1:0] irq_ack = 2'b00;
  logic       flag_wr_en = 1'b0;
  logic [1:0] flag_wr_data = 2'b00;
  logic [1:0] irq_flag;
  logic [1:0] irq_req;

  int n_chk = 0;
  int n_fail = 0;
  bit done = 1'b0;

  always #5 clk = ~clk;

  qbp_port u0 (
    .clk(clk), .rst_n(rst_n), .pad_ext(pad_ext), .pad_pd(pad_pd),
    .alt_out(alt_out), .alt_in(alt_in), .wr_en(wr_en), .wr_data(wr_data),
    .rmw_en(rmw_en), .rmw_op(rmw_op), .rmw_bit(rmw_bit), .disturb(disturb),
    .tst_bit(tst_bit), .pin_rd(pin_rd), .irq_mode(irq_mode), .irq_en(irq_en),
    .irq_ack(irq_ack), .flag_wr_en(flag_wr_en), .flag_wr_data(flag_wr_data),
    .irq_flag(irq_flag), .irq_req(irq_req)
  );

  // {is_write, op[1:0], bit[2:0], data[7:0], disturb[7:0], exp_pd[7:0], exp_tst, pad}
  localparam logic [31:0] TBL [9] = '{
    {1'b1, 2'd0, 3'd0, 8'hA5, 8'h00, 8'h5A, 1'b0, 1'b0},
    {1'b0, 2'd0, 3'd1, 8'h00, 8'h00, 8'h58, 1'b0, 1'b0},
    {1'b0, 2'd1, 3'd7, 8'h00, 8'h00, 8'hD8, 1'b1, 1'b0},
    {1'b0, 2'd2, 3'd0, 8'h00, 8'h00, 8'hD9, 1'b1, 1'b0},
    {1'b0, 2'd2, 3'd0, 8'h00, 8'h00, 8'hD9, 1'b0, 1'b0},
    {1'b0, 2'd0, 3'd3, 8'h00, 8'h20, 8'hF1, 1'b0, 1'b0},
    {1'b0, 2'd0, 3'd4, 8'h00, 8'h10, 8'hE1, 1'b0, 1'b0},
    {1'b1, 2'd0, 3'd0, 8'hFF, 8'h01, 8'h00, 1'b0, 1'b0},
    {1'b0, 2'd3, 3'd0, 8'h00, 8'h80, 8'h80, 1'b1, 1'b0}
  };

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic tick(input int n);
    for (int k = 0; k < n; k++) @(negedge clk);
  endtask

  task automatic do_write(input logic [7:0] d);
    wr_en = 1'b1; wr_data = d; tick(1); wr_en = 1'b0;
  endtask

  task automatic do_rmw(input logic [1:0] op, input logic [2:0] b);
    rmw_en = 1'b1; rmw_op = op; rmw_bit = b; tick(1); rmw_en = 1'b0;
  endtask

  initial begin : watchdog
    for (int k = 0; k < 100000; k++) begin
      @(posedge clk);
      if (done) disable watchdog;
    end
    n_chk++; n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    tick(3);
    rst_n = 1'b1;
    tick(1);
    // R1 reset state
    check("R1 pad_pd", pad_pd, 8'h00);
    check("R1 irq_flag", irq_flag, 2'b00);
    check("R1 pin_rd", pin_rd, 8'hFF);
    check("R1 tst_bit", tst_bit, 1'b0);

    // Table walk: R6 R7 R8 R2, observing the latch through pad_pd (alt_out all 1)
    for (int i = 0; i < 9; i++) begin
      logic [31:0] v;
      v = TBL[i];
      wr_en = v[31]; rmw_en = !v[31];
      rmw_op = v[30:29]; rmw_bit = v[28:26]; wr_data = v[25:18]; disturb = v[17:10];
      tick(1);
      wr_en = 1'b0; rmw_en = 1'b0; disturb = 8'h00;
      check($sformatf("R6/R7 table row %0d pad_pd", i), pad_pd, v[9:2]);
      check($sformatf("R8 table row %0d tst_bit", i), tst_bit, v[1]);
    end

    // R13 byte write beats read-modify-write
    do_write(8'hFF);
    wr_en = 1'b1; wr_data = 8'h0F; rmw_en = 1'b1; rmw_op = 2'd0; rmw_bit = 3'd7;
    tick(1);
    wr_en = 1'b0; rmw_en = 1'b0;
    check("R13 write wins", pad_pd, 8'hF0);
    do_write(8'hFF);
    tick(3);

    // R2 alt_out low pulls the pad down at once; R3/R4 pin read two edges later
    alt_out[5] = 1'b0;
    #1;
    check("R2 alt_out pulldown", pad_pd, 8'h20);
    tick(2);
    check("R3 pin read via alt pulldown", pin_rd, 8'hDF);
    check("R4 alt_in matches pin", alt_in, 8'hDF);
    alt_out[5] = 1'b1;
    // R5 alt_out ignored on interrupt bits
    alt_out[2] = 1'b0; alt_out[3] = 1'b0;
    #1;
    check("R5 alt_out ignored on int bits", pad_pd, 8'h00);
    alt_out = 8'hFF;
    // R3 external pull-down with latch 1
    pad_ext[6] = 1'b0;
    tick(1);
    check("R3 one edge not yet visible", pin_rd[6], 1'b1);
    tick(1);
    check("R3 external low read", pin_rd, 8'hBF);
    pad_ext[6] = 1'b1;
    tick(3);

    // R9 R10 edge capture with interrupt disabled
    irq_mode = 2'b11; irq_en = 2'b00;
    pad_ext[2] = 1'b0;
    tick(2);
    check("R9 no flag before scoring edge", irq_flag[0], 1'b0);
    tick(1);
    check("R9 edge sets flag", irq_flag[0], 1'b1);
    check("R10 disabled request low", irq_req, 2'b00);
    irq_en[0] = 1'b1;
    #1;
    check("R10 enabled request", irq_req, 2'b01);
    tick(3);
    check("R9 edge mode no repeat on steady low", irq_flag[0], 1'b1);

    // R11 same-cycle ack and new capture: capture wins
    pad_ext[2] = 1'b1;
    tick(3);
    pad_ext[2] = 1'b0;
    tick(2);
    irq_ack[0] = 1'b1;
    tick(1);
    irq_ack[0] = 1'b0;
    check("R11 capture beats ack", irq_flag[0], 1'b1);
    irq_ack[0] = 1'b1;
    tick(1);
    irq_ack[0] = 1'b0;
    check("R11 ack clears", irq_flag[0], 1'b0);
    pad_ext[2] = 1'b1;

    // R11 software write on channel 1
    pad_ext[3] = 1'b0;
    tick(3);
    check("R9 channel 1 edge", irq_flag[1], 1'b1);
    flag_wr_en = 1'b1; flag_wr_data = 2'b00;
    tick(1);
    flag_wr_en = 1'b0;
    check("R11 software clear", irq_flag, 2'b00);
    pad_ext[3] = 1'b1;
    tick(3);

    // R9 level mode: flag keeps returning while pin low
    irq_mode[0] = 1'b0;
    pad_ext[2] = 1'b0;
    tick(3);
    check("R9 level capture", irq_flag[0], 1'b1);
    irq_ack[0] = 1'b1;
    tick(1);
    irq_ack[0] = 1'b0;
    check("R9 level reasserts over ack", irq_flag[0], 1'b1);
    pad_ext[2] = 1'b1;
    tick(3);
    irq_ack[0] = 1'b1;
    tick(1);
    irq_ack[0] = 1'b0;
    check("R11 ack clears after release", irq_flag[0], 1'b0);
    irq_mode[0] = 1'b1;

    // R12 latch 0 on interrupt pin hides external edges
    do_rmw(2'd1, 3'd2);
    tick(4);
    flag_wr_en = 1'b1; flag_wr_data = 2'b00;
    tick(1);
    flag_wr_en = 1'b0;
    check("R12 pin held low", pin_rd[2], 1'b0);
    for (int k = 0; k < 3; k++) begin
      pad_ext[2] = 1'b0; tick(3);
      pad_ext[2] = 1'b1; tick(3);
    end
    check("R12 edges hidden", irq_flag[0], 1'b0);
    do_rmw(2'd0, 3'd2);
    tick(3);
    check("R12 pin released", pin_rd[2], 1'b1);
    pad_ext[2] = 1'b0;
    tick(3);
    check("R12 capture restored", irq_flag[0], 1'b1);

    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule